// File: doc/BRIEF.md
# Programmable Flag Offset Register Loader

This block holds the two thresholds that a FIFO channel's programmable flag logic compares against. The almost-empty threshold is n and the almost-full threshold is m. Each threshold is as wide as log2 of the FIFO depth. It is kept as a low byte register plus a narrow high register that carries only the bits above the low byte. The four registers share one byte-wide input bus and one byte-wide output bus. No register has an address. A write sequence pointer picks the next register to load, and a read sequence pointer picks the next register to return. Both pointers step through the same cyclic order and wrap after the fourth register.

A dual-purpose control pin has two roles. Its role is fixed by the level it holds while reset is active. If the pin is low during reset, the channel is in load mode: pulling the pin low later opens offset access, and raising it returns the channel to normal FIFO traffic. If the pin is high during reset, the channel is in second-enable mode: the pin acts as an active-high second write enable, and the offset registers keep their defaults. A load session may stop after any number of registers. The next session resumes at the register that follows the last one written.

The block drives the assembled thresholds to the flag comparators. It also drives two qualified request strobes that tell the FIFO core when a normal write or read is taking place. The memory, its pointers and the flag comparison are outside this block.

Top module: `ofs_loader`

## Requirements
- R1: A synchronous active-high reset sets both thresholds to the default of 7, clears the output bus to 0, and returns both sequence pointers to the empty-offset low byte.
- R2: In load mode, each rising clock edge with the pin low and the write enable low stores the input byte into the next register. The order is: empty-offset low byte (index 0), empty-offset high part (1), full-offset low byte (2), full-offset high part (3). The fifth such edge writes index 0 again.
- R3: A load session may end after any number of registers by raising the pin. No register changes while offset writes are not requested. The next session writes the register that follows the last one written.
- R4: In load mode, each rising edge with the pin low and both read enables low places the next register in the read sequence on the output bus, visible after that edge. High parts are zero-extended. On all other edges the output bus holds its value.
- R5: When an offset write and an offset read are requested on the same edge, the write is performed. The read is dropped: the output bus holds its value and the read pointer does not advance.
- R6: The pin level during reset fixes the mode until the next reset: low selects load mode, high selects second-enable mode. In second-enable mode the offset registers never change and the output bus is never loaded.
- R7: Each high-part register holds only the log2(depth) minus 8 bits above the low byte (5 bits for depth 8192). Written bits above that width are discarded and read back as zero. Each threshold output is {high part, low byte}.
- R8: The FIFO write request is active when the write enable is low and the pin is high, in either mode. The FIFO read request is active when both read enables are low and, in load mode only, the pin is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the offset write and read paths |
| rst | input | 1 | Synchronous active-high reset; also samples the mode |
| wen_n | input | 1 | Active-low write enable |
| ldwe2_n | input | 1 | Dual-purpose pin: active-low offset load, or active-high second write enable |
| ren1_n | input | 1 | First active-low read enable |
| ren2_n | input | 1 | Second active-low read enable |
| din | input | BYTE_W | Shared byte-wide data input |
| dout | output | BYTE_W | Registered byte-wide offset read-back bus |
| empty_ofs | output | OFS_W | Assembled almost-empty threshold n |
| full_ofs | output | OFS_W | Assembled almost-full threshold m |
| fifo_wr_req | output | 1 | Qualified normal FIFO write request |
| fifo_rd_req | output | 1 | Qualified normal FIFO read request |

## Verification
The hardest case to reach is a collision between the two pointers that run independently. It needs an offset write and an offset read on the same edge after the two pointers have moved apart. The bench first ends one load session early and starts a second session, so the write pointer sits on the full-offset high part. It then reads five times, which leaves the read pointer on the empty-offset high part. Only then does it issue the combined request. A follow-up read shows whether the dropped read had moved the read pointer. A second reset with the pin held high then shows that the same strobes leave the registers alone in second-enable mode.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;
  localparam int NUM_OFS_REGS = 4;
  localparam int IDX_W = $clog2(NUM_OFS_REGS);

  // Sequence order: each threshold is low byte first, then its high part
  typedef enum logic [IDX_W-1:0] {
    IDX_E_LO = 2'd0,
    IDX_E_HI = 2'd1,
    IDX_F_LO = 2'd2,
    IDX_F_HI = 2'd3
  } ofs_idx_t;
endpackage

// File: rtl/ofs_seq_ptr.sv
module ofs_seq_ptr
  import ofs_loader_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  output ofs_idx_t idx
);
  always_ff @(posedge clk) begin
    if (rst)
      idx <= IDX_E_LO;
    else if (step)
      idx <= ofs_idx_t'(idx + 1'b1);
  end

  // R2: pointer moves by exactly one slot per step and wraps, else holds
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    step |=> (idx == ofs_idx_t'($past(idx) + 1'b1)));
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(idx));
endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile
  import ofs_loader_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int OFS_W   = 13,
  parameter int DEF_OFS = 7,
  localparam int HI_W   = OFS_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  ofs_idx_t          widx,
  input  logic [BYTE_W-1:0] wdata,
  input  ofs_idx_t          ridx,
  output logic [BYTE_W-1:0] rdata,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs
);
  localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

  initial begin
    if (HI_W < 1 || HI_W >= BYTE_W)
      $error("ofs_regfile: OFS_W must exceed BYTE_W by 1 to BYTE_W-1 bits");
  end

  logic [BYTE_W-1:0] lo_q [2];
  logic [HI_W-1:0]   hi_q [2];

  // k = 0: empty threshold, k = 1: full threshold
  for (genvar k = 0; k < 2; k++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[k] <= DEF_V[BYTE_W-1:0];
        hi_q[k] <= DEF_V[OFS_W-1:BYTE_W];
      end else if (wr && widx[1] == k[0]) begin
        if (widx[0]) hi_q[k] <= wdata[HI_W-1:0];
        else         lo_q[k] <= wdata;
      end
    end
  end

  assign empty_ofs = {hi_q[0], lo_q[0]};
  assign full_ofs  = {hi_q[1], lo_q[1]};

  always_comb begin
    unique case (ridx)
      IDX_E_LO: rdata = lo_q[0];
      IDX_E_HI: rdata = {{(BYTE_W-HI_W){1'b0}}, hi_q[0]};
      IDX_F_LO: rdata = lo_q[1];
      default:  rdata = {{(BYTE_W-HI_W){1'b0}}, hi_q[1]};
    endcase
  end

  // R3: without a write strobe neither threshold moves
  p_thr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(empty_ofs) && $stable(full_ofs)));
  // R2: a write to an empty-side slot leaves the full threshold alone
  p_side_sel_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && !widx[1]) |=> $stable(full_ofs));
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_loader_pkg::*;
#(
  parameter int DEPTH   = 8192,
  parameter int BYTE_W  = 8,
  parameter int DEF_OFS = 7,
  parameter int OFS_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen_n,
  input  logic              ldwe2_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              fifo_wr_req,
  output logic              fifo_rd_req
);
  logic     load_mode;
  logic     ofs_wr, ofs_rd_req, ofs_rd;
  ofs_idx_t wr_idx, rd_idx;
  logic [BYTE_W-1:0] rd_byte;

  // Mode sampled from the dual-purpose pin while reset is held
  always_ff @(posedge clk) begin
    if (rst) load_mode <= ~ldwe2_n;
  end

  assign ofs_wr     = !rst && load_mode && !ldwe2_n && !wen_n;
  assign ofs_rd_req = !rst && load_mode && !ldwe2_n && !ren1_n && !ren2_n;
  assign ofs_rd     = ofs_rd_req && !ofs_wr;   // write wins a collision

  assign fifo_wr_req = !wen_n && ldwe2_n;
  assign fifo_rd_req = !ren1_n && !ren2_n && (ldwe2_n || !load_mode);

  ofs_seq_ptr u_wptr (.clk(clk), .rst(rst), .step(ofs_wr), .idx(wr_idx));
  ofs_seq_ptr u_rptr (.clk(clk), .rst(rst), .step(ofs_rd), .idx(rd_idx));

  ofs_regfile #(.BYTE_W(BYTE_W), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_regs (
    .clk(clk), .rst(rst), .wr(ofs_wr), .widx(wr_idx), .wdata(din),
    .ridx(rd_idx), .rdata(rd_byte), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (ofs_rd) dout <= rd_byte;
  end

  // R4: the bus only changes on an accepted offset read
  p_dout_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ofs_rd |=> $stable(dout));
  // R5: on a collision the read pointer stays put
  p_rd_dropped_r5: assert property (@(posedge clk) disable iff (rst)
    (ofs_wr && ofs_rd_req) |=> $stable(rd_idx));
  // R6: mode cannot change outside reset
  p_mode_locked_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(load_mode));
  // R6: second-enable mode never touches thresholds or bus
  p_we2_no_load_r6: assert property (@(posedge clk) disable iff (rst)
    !load_mode |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(dout)));
endmodule

// File: tb/tb_ofs_loader.sv
module tb_ofs_loader;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 13;

  logic clk = 0, rst = 1;
  logic wen_n = 1, ldwe2_n = 0, ren1_n = 1, ren2_n = 1;
  logic [BYTE_W-1:0] din = '0;
  logic [BYTE_W-1:0] dout;
  logic [OFS_W-1:0]  empty_ofs, full_ofs;
  logic fifo_wr_req, fifo_rd_req;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;   // 50 MHz

  ofs_loader #(.DEPTH(8192)) dut (
    .clk(clk), .rst(rst), .wen_n(wen_n), .ldwe2_n(ldwe2_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .dout(dout),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .fifo_wr_req(fifo_wr_req), .fifo_rd_req(fifo_rd_req)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    wen_n = 1; ren1_n = 1; ren2_n = 1; ldwe2_n = 1;
  endtask

  // Drive at negedge, let one posedge act, return at next negedge
  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset(logic pin);
    @(negedge clk);
    idle(); ldwe2_n = pin; rst = 1;
    cyc(); cyc();
    rst = 0; idle();
  endtask

  task automatic ofs_write(logic [7:0] v);
    idle(); ldwe2_n = 0; wen_n = 0; din = v;
    cyc(); idle();
  endtask

  task automatic ofs_read();
    idle(); ldwe2_n = 0; ren1_n = 0; ren2_n = 0;
    cyc(); idle();
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check("R1 empty default", empty_ofs, 7);
    check("R1 full default", full_ofs, 7);
    check("R1 dout cleared", dout, 0);
  endtask

  task automatic t_write_seq();
    ofs_write(8'h11);
    check("R2 e_lo", empty_ofs, 13'h0011);
    ofs_write(8'hFF);
    check("R7 e_hi masked", empty_ofs, 13'h1F11);
    ofs_write(8'h22);
    check("R2 f_lo", full_ofs, 13'h0022);
    ofs_write(8'h03);
    check("R2 f_hi", full_ofs, 13'h0322);
    ofs_write(8'h44);
    check("R2 wrap to e_lo", empty_ofs, 13'h1F44);
    check("R2 wrap full kept", full_ofs, 13'h0322);
  endtask

  task automatic t_partial();
    idle(); wen_n = 0; din = 8'hAA; cyc(); cyc(); idle();   // normal writes
    check("R3 no change when idle", empty_ofs, 13'h1F44);
    ofs_write(8'h06);
    check("R3 resume at e_hi", empty_ofs, 13'h0644);
    idle(); cyc();
    ofs_write(8'h33);
    check("R3 resume at f_lo", full_ofs, 13'h0333);
  endtask

  task automatic t_read();
    ofs_read(); check("R4 read e_lo", dout, 8'h44);
    cyc();      check("R4 hold", dout, 8'h44);
    ofs_read(); check("R4 read e_hi", dout, 8'h06);
    ofs_read(); check("R4 read f_lo", dout, 8'h33);
    ofs_read(); check("R7 read f_hi zero-ext", dout, 8'h03);
    ofs_read(); check("R4 read wraps", dout, 8'h44);
    idle(); ldwe2_n = 0; ren1_n = 0; cyc(); idle();          // one enable only
    check("R4 one enable no read", dout, 8'h44);
  endtask

  task automatic t_collide();
    idle(); ldwe2_n = 0; wen_n = 0; ren1_n = 0; ren2_n = 0; din = 8'h09;
    cyc(); idle();
    check("R5 write performed", full_ofs, 13'h0933);
    check("R5 read dropped", dout, 8'h44);
    ofs_read();
    check("R5 rd ptr held", dout, 8'h06);
  endtask

  task automatic t_strobes();
    idle(); wen_n = 0; #1;
    check("R8 wr pin high", fifo_wr_req, 1);
    ldwe2_n = 0; #1;
    check("R8 wr pin low", fifo_wr_req, 0);
    idle(); ren1_n = 0; ren2_n = 0; #1;
    check("R8 rd pin high", fifo_rd_req, 1);
    ldwe2_n = 0; #1;
    check("R8 rd load blocks", fifo_rd_req, 0);
    idle();
  endtask

  task automatic t_rereset();
    do_reset(1'b0);
    check("R1 reset restores", full_ofs, 7);
    ofs_write(8'h01);
    check("R1 wptr back to e_lo", empty_ofs, 13'h0001);
  endtask

  task automatic t_we2_mode();
    do_reset(1'b1);
    check("R6 defaults", empty_ofs, 7);
    ofs_write(8'h55); ofs_write(8'h66);
    check("R6 no offset write e", empty_ofs, 7);
    check("R6 no offset write f", full_ofs, 7);
    ofs_read();
    check("R6 no offset read", dout, 0);
    idle(); ldwe2_n = 0; ren1_n = 0; ren2_n = 0; #1;
    check("R8 rd ignores pin", fifo_rd_req, 1);
    idle(); wen_n = 0; ldwe2_n = 0; #1;
    check("R8 we2 low blocks", fifo_wr_req, 0);
    ldwe2_n = 1; #1;
    check("R8 we2 high writes", fifo_wr_req, 1);
    idle();
  endtask

  initial begin
    t_reset();
    t_write_seq();
    t_partial();
    t_read();
    t_collide();
    t_strobes();
    t_rereset();
    t_we2_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule